// File: doc/BRIEF.md
# Coupled Address-Operand Register File

This block holds three sets of eight registers: wide operand registers (X, 60 bits), address registers (A, 18 bits) and index registers (B, 18 bits). Writing an address register can also move data. Some A registers start a load into the X register with the same number. Others start a store of their paired X register. The block sends these transfers out on a small request interface. It writes returning load data into the X register the request names.

Before an address goes out, it is relocated by adding a base register. It is also checked against a limit register. An address that is not below the limit is reported and never sent. Each X register has a pending flag while its load is outstanding. A read port that selects a pending X register raises a stall so that the issue stage waits. Requests wait in a short in-order queue. The queue holds each entry stable until the memory side accepts it.

Top module: `coupled_regfile`

## Requirements
- R1: After reset every register reads zero, `mem_valid`, `rd_stall`, `range_err` and `req_full` are low, and the base and limit registers are zero.
- R2: B register 0 always reads zero, and a write to it has no effect.
- R3: A write of value v to A1..A5 with v below the limit queues a read request (`mem_write`=0) with address v plus base and `mem_tag` equal to the register number. It also sets that X register's pending flag. The request is visible on the clock edge that takes the write.
- R4: A response (`rsp_valid`, `rsp_tag`, `rsp_data`) writes `rsp_data` into X[`rsp_tag`] and clears its pending flag. A same-cycle write through the X write port to the same register takes priority.
- R5: `rd_stall` is high exactly while some read port selects a pending X register.
- R6: A write to A6 or A7 (in range) queues a write request (`mem_write`=1) carrying the value X6 or X7 held before that clock edge. An X write in the same cycle or in any later cycle does not change the stored data.
- R7: Writes to A0 and X0 queue no request, and A0 and X0 read back as written.
- R8: A write to A1..A7 with value not below the limit queues nothing and sets no pending flag. The A register is still written, and `range_err` is high for exactly the one cycle after that edge.
- R9: Requests leave in the order of their A writes, one per accepted handshake. While `mem_valid` is high and `mem_ready` low, address, direction, tag and data stay stable.
- R10: Read port kind encoding: 0 selects X, 1 selects A, 2 selects B, 3 returns zero. A and B values are zero-extended to 60 bits.
- R11: `req_full` is high while QD (4) requests are queued. The issuing side must not write a transfer-starting A register then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_kind | input | 3x2 | Register set per read port |
| rd_idx | input | 3x3 | Register number per read port |
| rd_data | output | 3x60 | Read data per port |
| rd_stall | output | 1 | A read port selects a pending X register |
| a_we | input | 1 | A write enable |
| a_idx | input | 3 | A register number |
| a_data | input | 18 | A write value |
| b_we | input | 1 | B write enable |
| b_idx | input | 3 | B register number |
| b_data | input | 18 | B write value |
| x_we | input | 1 | X write enable |
| x_idx | input | 3 | X register number |
| x_data | input | 60 | X write value |
| cfg_we | input | 1 | Load base and limit registers |
| cfg_base | input | 18 | Relocation base |
| cfg_limit | input | 18 | Field limit |
| mem_valid | output | 1 | Request present |
| mem_ready | input | 1 | Request accepted |
| mem_write | output | 1 | 1 store, 0 load |
| mem_addr | output | 18 | Relocated address |
| mem_wdata | output | 60 | Store data |
| mem_tag | output | 3 | Coupled register number |
| rsp_valid | input | 1 | Load data returning |
| rsp_tag | input | 3 | Destination X register |
| rsp_data | input | 60 | Load data |
| range_err | output | 1 | Previous A write was out of range |
| req_full | output | 1 | Request queue full |

## Verification
The two functions that can coincide are a store launch through A6 and a write of X6 through the X write port. Both take effect on the same clock edge. The bench drives both in one cycle with a different value on each. The queued store must carry the old X6 contents, and a later read of X6 must return the new value. A second collision is a queue that fills while `mem_ready` is held low. Mixed loads and stores must then come out in issue order with stable fields.

// File: rtl/coupled_regfile.sv
module coupled_regfile #(
  parameter int XW = 60,
  parameter int AW = 18,
  parameter int NR = 8,
  parameter int RP = 3,
  parameter int QD = 4,
  parameter int LD_LO = 1,
  parameter int LD_HI = 5,
  parameter int ST_LO = 6,
  localparam int IW = $clog2(NR),
  localparam int QW = (QD > 1) ? $clog2(QD) : 1,
  localparam int CW = $clog2(QD + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [RP-1:0][1:0]     rd_kind,
  input  logic [RP-1:0][IW-1:0]  rd_idx,
  output logic [RP-1:0][XW-1:0]  rd_data,
  output logic                   rd_stall,
  input  logic                   a_we,
  input  logic [IW-1:0]          a_idx,
  input  logic [AW-1:0]          a_data,
  input  logic                   b_we,
  input  logic [IW-1:0]          b_idx,
  input  logic [AW-1:0]          b_data,
  input  logic                   x_we,
  input  logic [IW-1:0]          x_idx,
  input  logic [XW-1:0]          x_data,
  input  logic                   cfg_we,
  input  logic [AW-1:0]          cfg_base,
  input  logic [AW-1:0]          cfg_limit,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic                   mem_write,
  output logic [AW-1:0]          mem_addr,
  output logic [XW-1:0]          mem_wdata,
  output logic [IW-1:0]          mem_tag,
  input  logic                   rsp_valid,
  input  logic [IW-1:0]          rsp_tag,
  input  logic [XW-1:0]          rsp_data,
  output logic                   range_err,
  output logic                   req_full
);
  localparam logic [IW-1:0] LLO = IW'(LD_LO);
  localparam logic [IW-1:0] LHI = IW'(LD_HI);
  localparam logic [IW-1:0] SLO = IW'(ST_LO);

  logic [XW-1:0] xr [NR];
  logic [AW-1:0] ar [NR];
  logic [AW-1:0] br [NR];
  logic [AW-1:0] base_q, limit_q;
  logic [NR-1:0] pend;

  logic [AW-1:0] q_addr [QD];
  logic [XW-1:0] q_data [QD];
  logic [IW-1:0] q_tag  [QD];
  logic          q_wr   [QD];
  logic [QW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire a_load  = a_we && a_idx >= LLO && a_idx <= LHI;
  wire a_store = a_we && a_idx >= SLO;
  wire in_rng  = a_data < limit_q;
  wire full    = cnt == CW'(QD);
  wire push    = (a_load || a_store) && in_rng && !full;
  wire pop     = mem_valid && mem_ready;

  assign req_full  = full;
  assign mem_valid = cnt != '0;
  assign mem_addr  = q_addr[rp];
  assign mem_wdata = q_data[rp];
  assign mem_tag   = q_tag[rp];
  assign mem_write = q_wr[rp];

  for (genvar p = 0; p < RP; p++) begin : g_rd
    always_comb begin
      case (rd_kind[p])
        2'd0:    rd_data[p] = xr[rd_idx[p]];
        2'd1:    rd_data[p] = XW'(ar[rd_idx[p]]);
        2'd2:    rd_data[p] = (rd_idx[p] == '0) ? '0 : XW'(br[rd_idx[p]]);
        default: rd_data[p] = '0;
      endcase
    end
  end

  always_comb begin
    rd_stall = 1'b0;
    for (int p = 0; p < RP; p++)
      if (rd_kind[p] == 2'd0 && pend[rd_idx[p]]) rd_stall = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) begin
        xr[i] <= '0;
        ar[i] <= '0;
        br[i] <= '0;
      end
      base_q    <= '0;
      limit_q   <= '0;
      pend      <= '0;
      range_err <= 1'b0;
    end else begin
      if (cfg_we) begin
        base_q  <= cfg_base;
        limit_q <= cfg_limit;
      end
      if (a_we) ar[a_idx] <= a_data;
      if (b_we && b_idx != '0) br[b_idx] <= b_data;
      if (rsp_valid) xr[rsp_tag] <= rsp_data;
      if (x_we) xr[x_idx] <= x_data;
      range_err <= (a_load || a_store) && !in_rng;
      for (int i = 0; i < NR; i++) begin
        if (rsp_valid && rsp_tag == IW'(i)) pend[i] <= 1'b0;
        if (push && a_load && a_idx == IW'(i)) pend[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == QW'(QD - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == QW'(QD - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= a_data + base_q;
      q_data[wp] <= a_store ? xr[a_idx] : '0;
      q_tag[wp]  <= a_idx;
      q_wr[wp]   <= a_store;
    end
  end

  p_b0_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    b_we && b_idx == '0 |=> br[0] == '0);

  p_load_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push && a_load |=> pend[$past(a_idx)] && mem_valid);

  p_rsp_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !(push && a_load && a_idx == rsp_tag) |=> !pend[$past(rsp_tag)]);

  p_oob_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_load || a_store) && !in_rng && !pop |=> cnt == $past(cnt) && range_err);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_wdata) && $stable(mem_tag));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(QD));
endmodule

// File: tb/tb_coupled_regfile.sv
`timescale 1ns/1ps
module tb_coupled_regfile;
  logic clk = 0, rst_n = 0;
  logic [2:0][1:0]  rd_kind = '0;
  logic [2:0][2:0]  rd_idx = '0;
  logic [2:0][59:0] rd_data;
  logic rd_stall;
  logic a_we = 0, b_we = 0, x_we = 0, cfg_we = 0;
  logic [2:0] a_idx = 0, b_idx = 0, x_idx = 0;
  logic [17:0] a_data = 0, b_data = 0, cfg_base = 0, cfg_limit = 0;
  logic [59:0] x_data = 0;
  logic mem_valid, mem_ready = 0, mem_write;
  logic [17:0] mem_addr;
  logic [59:0] mem_wdata;
  logic [2:0] mem_tag;
  logic rsp_valid = 0;
  logic [2:0] rsp_tag = 0;
  logic [59:0] rsp_data = 0;
  logic range_err, req_full;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coupled_regfile dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    a_we = 0; b_we = 0; x_we = 0; cfg_we = 0; rsp_valid = 0;
  endtask

  task automatic rd(input int p, input logic [1:0] k, input logic [2:0] i);
    rd_kind[p] = k; rd_idx[p] = i; #0.1;
  endtask

  task automatic wa(input logic [2:0] i, input logic [17:0] v);
    a_we = 1; a_idx = i; a_data = v;
  endtask

  task automatic wx(input logic [2:0] i, input logic [59:0] v);
    x_we = 1; x_idx = i; x_data = v;
  endtask

  task automatic take(input string req, input bit w, input logic [17:0] ad, input logic [2:0] tg, input logic [59:0] d);
    chk(mem_valid, req, mem_valid, 1);
    chk(mem_write == w && mem_addr == ad && mem_tag == tg, req, {mem_write, mem_tag, mem_addr}, {w, tg, ad});
    if (w) chk(mem_wdata == d, req, mem_wdata, d);
    mem_ready = 1; tick(); mem_ready = 0;
  endtask

  task automatic t_reset();
    rd(0, 0, 3); rd(1, 1, 5); rd(2, 2, 7);
    chk(rd_data[0] == 0 && rd_data[1] == 0 && rd_data[2] == 0, "R1", rd_data[0], 0);
    chk(!mem_valid && !rd_stall && !range_err && !req_full, "R1",
        {mem_valid, rd_stall, range_err, req_full}, 0);
    wa(1, 0); tick();
    chk(!mem_valid && range_err, "R1 limit zero", {mem_valid, range_err}, 1);
    cfg_we = 1; cfg_base = 18'h100; cfg_limit = 18'h1000; tick();
  endtask

  task automatic t_b0();
    b_we = 1; b_idx = 0; b_data = 18'h3ffff; tick();
    rd(0, 2, 0);
    chk(rd_data[0] == 0, "R2", rd_data[0], 0);
    b_we = 1; b_idx = 3; b_data = 18'h2abcd; tick();
    rd(0, 2, 3);
    chk(rd_data[0] == 60'h2abcd, "R10 B zero-extend", rd_data[0], 60'h2abcd);
    rd(1, 3, 3);
    chk(rd_data[1] == 0, "R10 kind 3", rd_data[1], 0);
  endtask

  task automatic t_load();
    wa(1, 18'h20); tick();
    chk(mem_valid && !mem_write && mem_addr == 18'h120 && mem_tag == 1, "R3",
        {mem_write, mem_tag, mem_addr}, {1'b0, 3'd1, 18'h120});
    rd(0, 0, 1); rd(1, 1, 1); rd(2, 0, 2);
    chk(rd_stall, "R5 pending", rd_stall, 1);
    chk(rd_data[1] == 60'h20, "R10 A read", rd_data[1], 60'h20);
    rd(0, 1, 1);
    chk(!rd_stall, "R5 not X", rd_stall, 0);
    rd(2, 0, 1);
    take("R3 pop", 0, 18'h120, 1, 0);
    chk(rd_stall, "R5 after issue", rd_stall, 1);
    rsp_valid = 1; rsp_tag = 1; rsp_data = 60'hfedcba987654321; tick();
    chk(!rd_stall, "R4 clear", rd_stall, 0);
    chk(rd_data[2] == 60'hfedcba987654321, "R4 data", rd_data[2], 60'hfedcba987654321);
    rd(2, 3, 0);
  endtask

  task automatic t_store();
    wx(6, 60'h111); tick();
    wa(6, 18'h40); wx(6, 60'h222); tick();
    rd(0, 0, 6);
    chk(rd_data[0] == 60'h222, "R6 new X6", rd_data[0], 60'h222);
    wx(6, 60'h333); tick();
    take("R6", 1, 18'h140, 6, 60'h111);
  endtask

  task automatic t_scratch();
    wa(0, 18'h55); wx(0, 60'h77); tick();
    chk(!mem_valid, "R7", mem_valid, 0);
    rd(0, 1, 0); rd(1, 0, 0);
    chk(rd_data[0] == 60'h55 && rd_data[1] == 60'h77, "R7 readback", rd_data[1], 60'h77);
  endtask

  task automatic t_range();
    wa(2, 18'h1000); tick();
    chk(!mem_valid && range_err, "R8", {mem_valid, range_err}, 1);
    rd(0, 1, 2); rd(1, 0, 2);
    chk(rd_data[0] == 60'h1000 && !rd_stall, "R8 A written no pend", {rd_stall, rd_data[0]}, 60'h1000);
    tick();
    chk(!range_err, "R8 one cycle", range_err, 0);
    wa(7, 18'h2000); tick();
    chk(!mem_valid && range_err, "R8 store", {mem_valid, range_err}, 1);
    tick();
  endtask

  task automatic t_order();
    wx(7, 60'habc); tick();
    wa(2, 18'h10); tick();
    wa(7, 18'h11); tick();
    wa(3, 18'h12); tick();
    chk(!req_full, "R11 three", req_full, 0);
    wa(4, 18'h13); tick();
    chk(req_full, "R11 four", req_full, 1);
    tick();
    chk(mem_addr == 18'h110 && mem_tag == 2, "R9 hold", mem_addr, 18'h110);
    take("R9 first", 0, 18'h110, 2, 0);
    chk(!req_full, "R11 drain", req_full, 0);
    take("R9 second", 1, 18'h111, 7, 60'habc);
    take("R9 third", 0, 18'h112, 3, 0);
    take("R9 fourth", 0, 18'h113, 4, 0);
    chk(!mem_valid, "R9 empty", mem_valid, 0);
    for (int t = 2; t <= 4; t++) begin
      rsp_valid = 1; rsp_tag = 3'(t); rsp_data = 60'(t); tick();
    end
    rd(0, 0, 3);
    chk(rd_data[0] == 3 && !rd_stall, "R4 tag 3", rd_data[0], 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_b0();
    t_load();
    t_store();
    t_scratch();
    t_range();
    t_order();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule